// File: doc/BRIEF.md
# Debug Status and Command Register

This block is a single 64-bit register on a simple register-access bus. The bus has a read strobe, a write strobe, write data and registered read data. The seven low bits have two unrelated meanings. A read returns processor and debug status. A write of ones fires command pulses toward the surrounding debug controller. Bits 63 to 7 are reserved.

Four status bits are sticky event flags: a reset occurred, the CPU suspended execution, a stop-clock action took place, and a debug action on the interconnect fired. A read returns these flags and clears them. The other three status bits show live levels: the CPU is in debug-interrupt mode, the CPU is stalled for any reason, and the controller is stalling the CPU.

Writes never change status. Each bit written as one produces a one-clock pulse in the cycle after the write strobe. The pulse for the system-management request also sets a separate sticky interrupt flag. The stop-clock pulse is fanned out over an external clock-disable mask. A bootstrap input decides whether the reset-occurred flag is already set when reset is released.

Top module: `dbg_stat_cmd_reg`

## Requirements
- R1: During and right after reset, `rd_vld`, `rd_data`, every command pulse, `clk_stop_p` and `sysmgmt_flag` are zero.
- R2: `rd_vld` is high exactly in the cycle after a cycle with `rd_stb` high. `rd_data` is loaded only at that point, and its bits 63..7 are always zero.
- R3: Sticky flags sit at these positions: bit 1 = CPU suspended (`evt_cpu_suspend`), bit 4 = interconnect debug action (`evt_bus_dbg_act`), bit 5 = stop-clock occurred (`evt_clk_stopped`), bit 6 = reset occurred (`evt_sys_reset`). An event sets its flag. The next read returns 1 for that bit and clears the flag, so a following read returns 0.
- R4: A read returns the flags as they stood before the read cycle. An event that arrives in the same cycle as `rd_stb` is not in that read, and it is kept for the next read.
- R5: Live bits carry the input level sampled in the read-strobe cycle: bit 0 = `lvl_dbgint_mode`, bit 2 = `lvl_cpu_stall`, bit 3 = `lvl_ctl_stall`.
- R6: In the cycle after `wr_stb`, each write-data bit at 1 gives a one-cycle high pulse: bit 0 → `dbg_stall_p`, bit 1 → `stop_clk_p`, bit 2 → `sysmgmt_req_p`, bit 3 → `dbgint_req_p`, bit 4 → `unstall_p`. Bits written together pulse together. Without `wr_stb` no pulse occurs.
- R7: Writes never alter status. Writing ones to bits 6, 5 or 63..7 produces no pulse and sets no flag. A write does not clear a flag that is already set.
- R8: `clk_stop_p` equals `clk_dis_mask`, sampled in the write cycle, during the `stop_clk_p` pulse. At all other times it is zero.
- R9: `sysmgmt_flag` rises together with `sysmgmt_req_p` and stays high until `sysmgmt_ack` is sampled high. A new request in the ack cycle keeps it set.
- R10: If `boot_rst_mark` is high when reset is released, the first read after release returns bit 6 = 1. If it is low, bit 6 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 64 | Write data |
| rd_vld | output | 1 | Read data valid, one cycle after `rd_stb` |
| rd_data | output | 64 | Registered read data |
| boot_rst_mark | input | 1 | Bootstrap strap: reset flag set at release |
| evt_sys_reset | input | 1 | Hard or soft reset event pulse |
| evt_clk_stopped | input | 1 | Stop-clock action event pulse |
| evt_bus_dbg_act | input | 1 | Interconnect debug action event pulse |
| evt_cpu_suspend | input | 1 | CPU suspended execution event pulse |
| lvl_ctl_stall | input | 1 | Controller is stalling the CPU |
| lvl_cpu_stall | input | 1 | CPU stalled for any reason |
| lvl_dbgint_mode | input | 1 | CPU in debug-interrupt mode |
| clk_dis_mask | input | 8 | Clocks selected for stop |
| sysmgmt_ack | input | 1 | Clears `sysmgmt_flag` |
| unstall_p | output | 1 | Unstall command pulse |
| dbgint_req_p | output | 1 | Debug-interrupt request pulse |
| sysmgmt_req_p | output | 1 | System-management interrupt request pulse |
| stop_clk_p | output | 1 | Stop-clock command pulse |
| dbg_stall_p | output | 1 | Debug-stall command pulse |
| clk_stop_p | output | 8 | Per-clock stop pulse, masked |
| sysmgmt_flag | output | 1 | Sticky system-management interrupt status |

## Verification
A read strobe can fall in the same cycle as an event on the bit it clears. The bench raises `rd_stb` and `evt_clk_stopped` on the same edge. It expects bit 5 to be 0 in that read and 1 in the next read. The system-management flag has a similar collision: a write that requests it is issued in the cycle `sysmgmt_ack` is high, and the flag must stay set. The bench also reads and writes in the same cycle and checks that the pulses fire while the read shows unchanged status.

// File: rtl/dbgsc_pkg.sv
package dbgsc_pkg;
  localparam int unsigned REG_W  = 64;
  localparam int unsigned STAT_W = 7;
  localparam int unsigned CMD_W  = 5;
  localparam int unsigned FLG_W  = 4;

  // status bit positions (software decodes these)
  localparam int unsigned B_DBGINT  = 0;
  localparam int unsigned B_SUSPEND = 1;
  localparam int unsigned B_CPUSTL  = 2;
  localparam int unsigned B_CTLSTL  = 3;
  localparam int unsigned B_DBGACT  = 4;
  localparam int unsigned B_STOPEV  = 5;
  localparam int unsigned B_RSTEV   = 6;

  // command bits, packed msb first = write bit 4 down to bit 0
  typedef struct packed {
    logic unstall;
    logic dbgint_req;
    logic sysmgmt_req;
    logic stop_clk;
    logic dbg_stall;
  } cmd_t;

  // sticky flag slots
  localparam int unsigned F_SUSPEND = 0;
  localparam int unsigned F_DBGACT  = 1;
  localparam int unsigned F_STOPEV  = 2;
  localparam int unsigned F_RSTEV   = 3;
endpackage

// File: rtl/dbgsc_sticky.sv
module dbgsc_sticky #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_d;

  always_comb begin
    flag_d = flag_o;
    if (rd_clr_i) flag_d = '0;
    flag_d = flag_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= flag_d;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i))); // R3
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> ((flag_o & ~$past(set_i)) == '0)); // R4
endmodule

// File: rtl/dbgsc_cmd.sv
module dbgsc_cmd
  import dbgsc_pkg::*;
#(
  parameter int unsigned N_CLK = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  cmd_t             wr_cmd,
  input  logic [N_CLK-1:0] clk_mask,
  input  logic             ack_i,
  output cmd_t             cmd_q,
  output logic [N_CLK-1:0] clk_stop_q,
  output logic             smi_flag_q
);
  cmd_t             cmd_d;
  logic [N_CLK-1:0] clk_stop_d;
  logic             smi_flag_d;

  always_comb begin
    cmd_d      = wr_stb ? wr_cmd : '0;
    clk_stop_d = '0;
    for (int i = 0; i < int'(N_CLK); i++)
      clk_stop_d[i] = cmd_d.stop_clk & clk_mask[i];
    smi_flag_d = cmd_d.sysmgmt_req | (smi_flag_q & ~ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      clk_stop_q <= '0;
      smi_flag_q <= 1'b0;
    end else begin
      cmd_q      <= cmd_d;
      clk_stop_q <= clk_stop_d;
      smi_flag_q <= smi_flag_d;
    end
  end

  AST_NO_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> (cmd_q == '0)); // R6
  AST_STOP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (|clk_stop_q) |-> cmd_q.stop_clk); // R8
  AST_SMI_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.sysmgmt_req |-> smi_flag_q); // R9
endmodule

// File: rtl/dbgsc_rdport.sv
module dbgsc_rdport #(
  parameter int unsigned REG_W  = 64,
  parameter int unsigned STAT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [STAT_W-1:0] stat_i,
  output logic              rd_vld,
  output logic [REG_W-1:0]  rd_data
);
  localparam int unsigned PAD_W = REG_W - STAT_W;

  logic [REG_W-1:0] data_d;

  always_comb begin
    data_d = {{PAD_W{1'b0}}, stat_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_stb;
      if (rd_stb) rd_data <= data_d;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_vld); // R2
  AST_RD_NO_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_vld); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:STAT_W] == '0); // R2
endmodule

// File: rtl/dbg_stat_cmd_reg.sv
module dbg_stat_cmd_reg
  import dbgsc_pkg::*;
#(
  parameter int unsigned N_CLK = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic [63:0]      wr_data,
  output logic             rd_vld,
  output logic [63:0]      rd_data,
  input  logic             boot_rst_mark,
  input  logic             evt_sys_reset,
  input  logic             evt_clk_stopped,
  input  logic             evt_bus_dbg_act,
  input  logic             evt_cpu_suspend,
  input  logic             lvl_ctl_stall,
  input  logic             lvl_cpu_stall,
  input  logic             lvl_dbgint_mode,
  input  logic [N_CLK-1:0] clk_dis_mask,
  input  logic             sysmgmt_ack,
  output logic             unstall_p,
  output logic             dbgint_req_p,
  output logic             sysmgmt_req_p,
  output logic             stop_clk_p,
  output logic             dbg_stall_p,
  output logic [N_CLK-1:0] clk_stop_p,
  output logic             sysmgmt_flag
);
  // one-shot after reset release for the bootstrap strap
  logic armed_q, armed_d;
  logic [FLG_W-1:0]  flg_set, flg_q;
  logic [STAT_W-1:0] stat;
  cmd_t              wr_cmd, cmd_q;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data[REG_W-1:CMD_W];

  always_comb begin
    armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end

  always_comb begin
    flg_set            = '0;
    flg_set[F_SUSPEND] = evt_cpu_suspend;
    flg_set[F_DBGACT]  = evt_bus_dbg_act;
    flg_set[F_STOPEV]  = evt_clk_stopped;
    flg_set[F_RSTEV]   = evt_sys_reset | (armed_q & boot_rst_mark);
  end

  dbgsc_sticky #(.W(FLG_W)) u_sticky (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (flg_set),
    .rd_clr_i (rd_stb),
    .flag_o   (flg_q)
  );

  always_comb begin
    stat            = '0;
    stat[B_DBGINT]  = lvl_dbgint_mode;
    stat[B_SUSPEND] = flg_q[F_SUSPEND];
    stat[B_CPUSTL]  = lvl_cpu_stall;
    stat[B_CTLSTL]  = lvl_ctl_stall;
    stat[B_DBGACT]  = flg_q[F_DBGACT];
    stat[B_STOPEV]  = flg_q[F_STOPEV];
    stat[B_RSTEV]   = flg_q[F_RSTEV];
  end

  dbgsc_rdport #(.REG_W(REG_W), .STAT_W(STAT_W)) u_rdport (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .stat_i  (stat),
    .rd_vld  (rd_vld),
    .rd_data (rd_data)
  );

  assign wr_cmd = cmd_t'(wr_data[CMD_W-1:0]);

  dbgsc_cmd #(.N_CLK(N_CLK)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_cmd     (wr_cmd),
    .clk_mask   (clk_dis_mask),
    .ack_i      (sysmgmt_ack),
    .cmd_q      (cmd_q),
    .clk_stop_q (clk_stop_p),
    .smi_flag_q (sysmgmt_flag)
  );

  assign unstall_p     = cmd_q.unstall;
  assign dbgint_req_p  = cmd_q.dbgint_req;
  assign sysmgmt_req_p = cmd_q.sysmgmt_req;
  assign stop_clk_p    = cmd_q.stop_clk;
  assign dbg_stall_p   = cmd_q.dbg_stall;

  AST_BOOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(armed_q) && $past(boot_rst_mark)) |-> flg_q[F_RSTEV]); // R10
  AST_WR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rd_stb) |=> ((flg_q & $past(flg_q)) == $past(flg_q))); // R7
endmodule

// File: tb/dbg_stat_cmd_reg_bench.sv
module dbg_stat_cmd_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_stb, wr_stb;
  logic [63:0] wr_data;
  logic        rd_vld;
  logic [63:0] rd_data;
  logic        boot_rst_mark;
  logic        evt_sys_reset, evt_clk_stopped, evt_bus_dbg_act, evt_cpu_suspend;
  logic        lvl_ctl_stall, lvl_cpu_stall, lvl_dbgint_mode;
  logic [7:0]  clk_dis_mask;
  logic        sysmgmt_ack;
  logic        unstall_p, dbgint_req_p, sysmgmt_req_p, stop_clk_p, dbg_stall_p;
  logic [7:0]  clk_stop_p;
  logic        sysmgmt_flag;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  dbg_stat_cmd_reg #(.N_CLK(8)) u_dbg_stat_cmd_reg (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_vld(rd_vld), .rd_data(rd_data),
    .boot_rst_mark(boot_rst_mark), .evt_sys_reset(evt_sys_reset),
    .evt_clk_stopped(evt_clk_stopped), .evt_bus_dbg_act(evt_bus_dbg_act),
    .evt_cpu_suspend(evt_cpu_suspend), .lvl_ctl_stall(lvl_ctl_stall),
    .lvl_cpu_stall(lvl_cpu_stall), .lvl_dbgint_mode(lvl_dbgint_mode),
    .clk_dis_mask(clk_dis_mask), .sysmgmt_ack(sysmgmt_ack),
    .unstall_p(unstall_p), .dbgint_req_p(dbgint_req_p),
    .sysmgmt_req_p(sysmgmt_req_p), .stop_clk_p(stop_clk_p),
    .dbg_stall_p(dbg_stall_p), .clk_stop_p(clk_stop_p),
    .sysmgmt_flag(sysmgmt_flag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] pulses();
    return {unstall_p, dbgint_req_p, sysmgmt_req_p, stop_clk_p, dbg_stall_p};
  endfunction

  task automatic idle_inputs();
    rd_stb = 0; wr_stb = 0; wr_data = '0;
    evt_sys_reset = 0; evt_clk_stopped = 0; evt_bus_dbg_act = 0; evt_cpu_suspend = 0;
    lvl_ctl_stall = 0; lvl_cpu_stall = 0; lvl_dbgint_mode = 0;
    clk_dis_mask = '0; sysmgmt_ack = 0;
  endtask

  task automatic do_reset(input logic boot);
    @(negedge clk);
    idle_inputs();
    boot_rst_mark = boot;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // read; rd_data is sampled at the negedge after the strobe edge
  task automatic do_read(output logic [63:0] val);
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0;
    chk("R2 rd_vld", {63'd0, rd_vld}, 64'd1);
    val = rd_data;
  endtask

  task automatic pulse_evt(ref logic e);
    @(negedge clk); e = 1;
    @(negedge clk); e = 0;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1 rd_vld/data", {rd_vld, rd_data[62:0]}, 64'd0);
    chk("R1 pulses", {51'd0, pulses(), clk_stop_p}, 64'd0);
    chk("R1 sysmgmt_flag", {63'd0, sysmgmt_flag}, 64'd0);
  endtask

  task automatic t_boot();
    logic [63:0] v;
    do_reset(1'b1);
    repeat (2) @(negedge clk);
    do_read(v);
    chk("R10 boot mark set", {63'd0, v[6]}, 64'd1);
    do_read(v);
    chk("R10 boot flag cleared", {63'd0, v[6]}, 64'd0);
    do_reset(1'b0);
    repeat (2) @(negedge clk);
    do_read(v);
    chk("R10 boot mark clear", {63'd0, v[6]}, 64'd0);
  endtask

  task automatic t_sticky();
    logic [63:0] v;
    pulse_evt(evt_cpu_suspend);
    pulse_evt(evt_bus_dbg_act);
    pulse_evt(evt_clk_stopped);
    pulse_evt(evt_sys_reset);
    repeat (3) @(negedge clk);
    do_read(v);
    chk("R3 all sticky set", v, 64'h72);
    do_read(v);
    chk("R3 sticky cleared by read", v, 64'h0);
    pulse_evt(evt_bus_dbg_act);
    do_read(v);
    chk("R3 single flag bit4", v, 64'h10);
  endtask

  task automatic t_collision();
    logic [63:0] v;
    @(negedge clk); rd_stb = 1; evt_clk_stopped = 1;
    @(negedge clk); rd_stb = 0; evt_clk_stopped = 0;
    chk("R4 same-cycle event not in read", rd_data, 64'h0);
    do_read(v);
    chk("R4 same-cycle event kept", v, 64'h20);
    do_read(v);
    chk("R4 cleared afterwards", v, 64'h0);
  endtask

  task automatic t_levels();
    logic [63:0] v;
    @(negedge clk); lvl_dbgint_mode = 1; lvl_ctl_stall = 1;
    do_read(v);
    chk("R5 levels 0,3", v, 64'h09);
    @(negedge clk); lvl_dbgint_mode = 0; lvl_ctl_stall = 0; lvl_cpu_stall = 1;
    do_read(v);
    chk("R5 level 2", v, 64'h04);
    @(negedge clk); lvl_cpu_stall = 0;
    chk("R2 rd_data held without strobe", rd_data, 64'h04);
    do_read(v);
    chk("R5 levels low", v, 64'h0);
  endtask

  task automatic t_write_pulses();
    for (int b = 0; b < 5; b++) begin
      @(negedge clk); wr_stb = 1; wr_data = 64'd1 << b;
      @(negedge clk); wr_stb = 0; wr_data = '0;
      chk($sformatf("R6 pulse bit%0d", b), {59'd0, pulses()}, 64'd1 << b);
      @(negedge clk);
      chk($sformatf("R6 pulse one cycle bit%0d", b), {59'd0, pulses()}, 64'd0);
    end
    @(negedge clk); wr_stb = 1; wr_data = 64'h15;
    @(negedge clk); wr_stb = 0; wr_data = 64'h1F;
    chk("R6 simultaneous pulses", {59'd0, pulses()}, 64'h15);
    @(negedge clk);
    chk("R6 no pulse without wr_stb", {59'd0, pulses()}, 64'd0);
    wr_data = '0;
    @(negedge clk); sysmgmt_ack = 1;
    @(negedge clk); sysmgmt_ack = 0;
  endtask

  task automatic t_write_no_status();
    logic [63:0] v;
    pulse_evt(evt_cpu_suspend);
    @(negedge clk); wr_stb = 1; wr_data = 64'hFFFF_FFFF_FFFF_FFE0;
    @(negedge clk); wr_stb = 0; wr_data = '0;
    chk("R7 reserved/status write no pulse", {56'd0, pulses(), 3'd0}, 64'd0);
    // read and write in the same cycle
    @(negedge clk); rd_stb = 1; wr_stb = 1; wr_data = 64'h7F;
    @(negedge clk); rd_stb = 0; wr_stb = 0; wr_data = '0;
    chk("R7 write keeps flag, no new flags", rd_data, 64'h02);
    chk("R6 pulses with concurrent read", {59'd0, pulses()}, 64'h1F);
    do_read(v);
    chk("R7 write set nothing", v, 64'h0);
    @(negedge clk); sysmgmt_ack = 1;
    @(negedge clk); sysmgmt_ack = 0;
  endtask

  task automatic t_stopclk_mask();
    @(negedge clk); wr_stb = 1; wr_data = 64'h2; clk_dis_mask = 8'hA5;
    @(negedge clk); wr_stb = 0; wr_data = '0; clk_dis_mask = 8'hFF;
    chk("R8 masked stop pulse", {55'd0, stop_clk_p, clk_stop_p}, {55'd0, 1'b1, 8'hA5});
    @(negedge clk);
    chk("R8 mask alone no pulse", {56'd0, clk_stop_p}, 64'd0);
    @(negedge clk); wr_stb = 1; wr_data = 64'h1;
    @(negedge clk); wr_stb = 0; wr_data = '0;
    chk("R8 other command no clock stop", {56'd0, clk_stop_p}, 64'd0);
    clk_dis_mask = '0;
  endtask

  task automatic t_smi_flag();
    chk("R9 flag idle", {63'd0, sysmgmt_flag}, 64'd0);
    @(negedge clk); wr_stb = 1; wr_data = 64'h4;
    @(negedge clk); wr_stb = 0; wr_data = '0;
    chk("R9 flag with pulse", {62'd0, sysmgmt_req_p, sysmgmt_flag}, 64'd3);
    repeat (3) @(negedge clk);
    chk("R9 flag held", {63'd0, sysmgmt_flag}, 64'd1);
    @(negedge clk); sysmgmt_ack = 1; wr_stb = 1; wr_data = 64'h4;
    @(negedge clk); sysmgmt_ack = 0; wr_stb = 0; wr_data = '0;
    chk("R9 request wins over ack", {63'd0, sysmgmt_flag}, 64'd1);
    @(negedge clk); sysmgmt_ack = 1;
    @(negedge clk); sysmgmt_ack = 0;
    chk("R9 ack clears", {63'd0, sysmgmt_flag}, 64'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    boot_rst_mark = 0;
    idle_inputs();
    t_reset();
    t_boot();
    t_sticky();
    t_collision();
    t_levels();
    t_write_pulses();
    t_write_no_status();
    t_stopclk_mask();
    t_smi_flag();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule